// File: doc/BRIEF.md
# Three-Phase Five-Level Notched Gate Pattern Generator

This block drives the switches of a three-phase inverter. Each phase is built from two H-bridge modules whose outputs add in series, so a phase can sit at five voltage levels: -2E, -E, 0, +E and +2E. A quarter of the fundamental period is described by twelve programmable switching points. The first three switching points move the phase between 0 and E. The other nine move it between E and 2E. Together they place notches on the staircase so that chosen low-order harmonics cancel. The block rebuilds the full period from that quarter using mirror and sign symmetry. It turns each level into the eight switch commands of the two bridges and produces the other two phases from the same table at fixed phase lags.

A free-running phase accumulator sets the output frequency, with one tuning word added per clock. Software may rewrite the switching points at any time. Such writes land in a staging copy, and that copy becomes active only when the accumulator wraps, so a period never mixes two tables. Dead time, the solving of the switching points and the power stage all sit outside this block.

Top module: `she_gate_gen`

## Requirements
- R1: While `rst_i` is high, every 8-bit phase group of `gate_o` reads 8'b10101010 (the zero level) and the accumulator is cleared. Both the staging table and the active table take the defaults 2440, 2854, 3571, 6463, 6882, 8422, 8783, 9986, 10627, 11107, 15268, 15659 for points 0 to 11.
- R2: On each clock the 16-bit accumulator adds `tune_i` modulo 65536. `gate_o` is registered and reflects the accumulator value and active table as they were before that clock edge (one cycle of latency).
- R3: Within a quarter, the folded position q is compared with each active point. Let k be the count of points with value <= q. The magnitude is 0 for k = 0 or 2, 1 for any odd k, and 2 for an even k of 4 or more.
- R4: The top two phase bits select the quadrant, and the low 14 bits give the position f. In quadrants 1 and 3, q = 16383 - f; otherwise q = f. In quadrants 2 and 3 the level is negative.
- R5: Phase A uses the accumulator value. Phase B uses the accumulator minus 21845 and phase C uses the accumulator minus 43691, both modulo 65536. All three share one table.
- R6: The switch bits of a phase, from the most significant bit down, are S11 S12 S13 S14 S21 S22 S23 S24. The patterns are: 0 gives 10101010, +E gives 10011010, -E gives 01101010, +2E gives 10011001, -2E gives 01100110.
- R7: In every phase group, bits 7/6, 5/4, 3/2 and 1/0 are always complements of each other.
- R8: A write with `wr_en_i` high stores `wr_data_i` into staging point `wr_addr_i`. The active table does not change until a clock edge on which the accumulator addition carries out of bit 15. On that edge the active table takes the staging contents held before the edge.
- R9: A write to an address of 12 or above is ignored.
- R10: `gate_o[7:0]` carries phase A, `gate_o[15:8]` carries phase B and `gate_o[23:16]` carries phase C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tune_i | input | 16 | Phase increment added each clock |
| wr_en_i | input | 1 | Staging table write strobe |
| wr_addr_i | input | 4 | Switching point index |
| wr_data_i | input | 14 | Switching point, as a fraction of a quarter period |
| gate_o | output | 24 | Registered switch commands for the three phases |

## Verification
The hardest case to reach is a table write that is still waiting in staging while the old table keeps driving the outputs. The outputs must then switch to the new table exactly on the wrapping edge, with no change one cycle earlier or later. The bench writes a whole new table shortly after a wrap using a small tuning word, so thousands of cycles pass before the next carry. It also adds a write to an out-of-range index. A running accumulator model predicts the edge on which the swap must land. Before that, a unit-step sweep walks phase A through every one of the 65536 accumulator values, so every quadrant boundary and every switching point edge is compared against the bench's own arithmetic.

// File: rtl/she_gate_pkg.sv
package she_gate_pkg;

  localparam int PHASE_W = 16;
  localparam int ANG_W   = PHASE_W - 2;
  localparam int N_ANG   = 12;
  localparam int LOW_CNT = 3;
  localparam int ADDR_W  = $clog2(N_ANG);
  localparam int CNT_W   = $clog2(N_ANG + 1);
  localparam int SW_W    = 8;
  localparam int N_PH    = 3;

  typedef logic [N_ANG-1:0][ANG_W-1:0] ang_tbl_t;

  typedef enum logic [2:0] {
    LV_NEG2 = 3'd0,
    LV_NEG1 = 3'd1,
    LV_ZERO = 3'd2,
    LV_POS1 = 3'd3,
    LV_POS2 = 3'd4
  } level_t;

  function automatic logic [ANG_W-1:0] default_angle(input int idx);
    case (idx)
      0:       return ANG_W'(2440);
      1:       return ANG_W'(2854);
      2:       return ANG_W'(3571);
      3:       return ANG_W'(6463);
      4:       return ANG_W'(6882);
      5:       return ANG_W'(8422);
      6:       return ANG_W'(8783);
      7:       return ANG_W'(9986);
      8:       return ANG_W'(10627);
      9:       return ANG_W'(11107);
      10:      return ANG_W'(15268);
      default: return ANG_W'(15659);
    endcase
  endfunction

  // Count of crossed points -> signed level
  function automatic level_t band_level(input logic [CNT_W-1:0] k, input logic neg);
    logic [1:0] mag;
    if (k[0])                        mag = 2'd1;
    else if (int'(k) > LOW_CNT)      mag = 2'd2;
    else                             mag = 2'd0;
    case ({neg, mag})
      3'b001:  return LV_POS1;
      3'b010:  return LV_POS2;
      3'b101:  return LV_NEG1;
      3'b110:  return LV_NEG2;
      default: return LV_ZERO;
    endcase
  endfunction

  // Level -> {S11,S12,S13,S14,S21,S22,S23,S24}
  function automatic logic [SW_W-1:0] level_gates(input level_t lv);
    case (lv)
      LV_POS1: return 8'b1001_1010;
      LV_NEG1: return 8'b0110_1010;
      LV_POS2: return 8'b1001_1001;
      LV_NEG2: return 8'b0110_0110;
      default: return 8'b1010_1010;
    endcase
  endfunction

endpackage

// File: rtl/she_angle_bank.sv
module she_angle_bank
  import she_gate_pkg::*;
#(
  parameter int N  = N_ANG,
  parameter int W  = ANG_W,
  parameter int AW = ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [W-1:0]        wr_data_i,
  input  logic                wrap_i,
  output logic [N-1:0][W-1:0] active_o
);

  logic [N-1:0][W-1:0] shadow_q;
  logic                wr_hit;

  assign wr_hit = wr_en_i && (int'(wr_addr_i) < N);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < N; i++) begin
        shadow_q[i] <= W'(default_angle(i));
        active_o[i] <= W'(default_angle(i));
      end
    end else begin
      if (wrap_i) active_o <= shadow_q;
      if (wr_hit) shadow_q[wr_addr_i] <= wr_data_i;
    end
  end

  AST_BANK_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_i |=> $stable(active_o)); // R8
  AST_WRAP_COPY: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_i |=> active_o == $past(shadow_q)); // R8

endmodule

// File: rtl/she_level_slicer.sv
module she_level_slicer
  import she_gate_pkg::*;
#(
  parameter int N  = N_ANG,
  parameter int PW = PHASE_W,
  parameter int CW = CNT_W
) (
  input  logic [PW-1:0]          phase_i,
  input  logic [N-1:0][PW-3:0]   angles_i,
  output level_t                 level_o
);

  localparam int FW = PW - 2;

  logic [FW-1:0] pos_raw;
  logic [FW-1:0] pos_fold;
  logic [CW-1:0] crossed;

  assign pos_raw  = phase_i[FW-1:0];
  assign pos_fold = phase_i[PW-2] ? ~pos_raw : pos_raw;

  always_comb begin
    crossed = '0;
    for (int i = 0; i < N; i++)
      if (angles_i[i] <= pos_fold) crossed = crossed + CW'(1);
  end

  assign level_o = band_level(crossed, phase_i[PW-1]);

endmodule

// File: rtl/she_gate_gen.sv
module she_gate_gen
  import she_gate_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [PHASE_W-1:0]     tune_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [ANG_W-1:0]       wr_data_i,
  output logic [N_PH*SW_W-1:0]   gate_o
);

  localparam int unsigned FULL  = 2 ** PHASE_W;
  localparam logic [PHASE_W-1:0] LAG_B = PHASE_W'(FULL / 3);
  localparam logic [PHASE_W-1:0] LAG_C = PHASE_W'((2 * FULL + 1) / 3);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] acc_next;
  logic               wrap;
  ang_tbl_t           active;
  logic [PHASE_W-1:0] ph [N_PH];
  level_t             lvl [N_PH];

  assign {wrap, acc_next} = {1'b0, acc_q} + {1'b0, tune_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) acc_q <= '0;
    else       acc_q <= acc_next;
  end

  she_angle_bank u_bank (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wrap_i    (wrap),
    .active_o  (active)
  );

  assign ph[0] = acc_q;
  assign ph[1] = acc_q - LAG_B;
  assign ph[2] = acc_q - LAG_C;

  for (genvar p = 0; p < N_PH; p++) begin : g_phase
    she_level_slicer u_slice (
      .phase_i  (ph[p]),
      .angles_i (active),
      .level_o  (lvl[p])
    );

    always_ff @(posedge clk_i) begin
      if (rst_i) gate_o[p*SW_W +: SW_W] <= level_gates(LV_ZERO);
      else       gate_o[p*SW_W +: SW_W] <= level_gates(lvl[p]);
    end

    AST_HALF_SIGN: assert property (@(posedge clk_i) disable iff (rst_i)
      ph[p][PHASE_W-1] ? (lvl[p] <= LV_ZERO) : (lvl[p] >= LV_ZERO)); // R4

    for (genvar l = 0; l < SW_W / 2; l++) begin : g_leg
      AST_LEG_COMPLEMENT: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_o[p*SW_W + 2*l] != gate_o[p*SW_W + 2*l + 1]); // R7
    end
  end

endmodule

// File: tb/she_gate_gen_tb.sv
module she_gate_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tune = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [13:0] wr_data = '0;
  logic [23:0] gate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_acc;
  int          m_act [12];
  int          m_sh  [12];
  int          wraps = 0;

  always #10 clk = ~clk;

  she_gate_gen u_dut (
    .clk_i     (clk),
    .rst_i     (rst),
    .tune_i    (tune),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .gate_o    (gate)
  );

  function automatic logic [7:0] pat(input int lv);
    case (lv)
      1:       return 8'b10011010;
      -1:      return 8'b01101010;
      2:       return 8'b10011001;
      -2:      return 8'b01100110;
      default: return 8'b10101010;
    endcase
  endfunction

  // R3 R4 R6: level of one phase from its own phase value
  function automatic logic [7:0] exp_phase(input logic [15:0] p, input int tbl [12]);
    int f, q, k, mag;
    f = int'(p[13:0]);
    q = p[14] ? 16383 - f : f;
    k = 0;
    for (int j = 0; j < 12; j++) if (tbl[j] <= q) k++;
    mag = (k <= 3) ? (k % 2) : (2 - (k % 2));
    return pat(p[15] ? -mag : mag);
  endfunction

  function automatic int dflt(input int i);
    int d [12] = '{2440, 2854, 3571, 6463, 6882, 8422, 8783, 9986, 10627, 11107, 15268, 15659};
    return d[i];
  endfunction

  // One clock: model the edge just taken, then compare
  task automatic tick();
    logic [23:0] exp;
    logic [16:0] s;
    logic        ok;
    @(posedge clk);
    #1;
    exp = {exp_phase(m_acc - 16'd43691, m_act),
           exp_phase(m_acc - 16'd21845, m_act),
           exp_phase(m_acc, m_act)};
    s = {1'b0, m_acc} + {1'b0, tune};
    m_acc = s[15:0];
    if (s[16]) begin
      for (int j = 0; j < 12; j++) m_act[j] = m_sh[j];
      wraps++;
    end
    if (wr_en && wr_addr < 12) m_sh[wr_addr] = int'(wr_data);
    checks++;
    if (gate !== exp) begin
      errors++;
      $display("FAIL R2 R3 R4 R5 R6 R8 R9 R10 acc-model=%h gate actual=%h expected=%h",
               m_acc, gate, exp);
    end
    ok = 1'b1;
    for (int j = 0; j < 12; j++) if (gate[2*j] === gate[2*j+1]) ok = 1'b0;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R7 leg pair not complementary actual=%h expected=complement pairs", gate);
    end
  endtask

  initial begin
    for (int j = 0; j < 12; j++) begin
      m_act[j] = dflt(j);
      m_sh[j]  = dflt(j);
    end
    m_acc = '0;
    // R1: reset state
    for (int c = 0; c < 3; c++) @(posedge clk);
    #1;
    checks++;
    if (gate !== {3{8'b10101010}}) begin
      errors++;
      $display("FAIL R1 reset gates actual=%h expected=%h", gate, {3{8'b10101010}});
    end
    rst = 1'b0;

    // R2 R3 R4 R5: unit-step sweep over the whole period plus a little
    tune = 16'd1;
    for (int c = 0; c < 65540; c++) tick();

    // Larger step through many wraps with default tables
    tune = 16'd4099;
    for (int c = 0; c < 3000; c++) tick();

    // R8 R9: stage a new table right after a wrap, slow step
    tune = 16'd3;
    while (m_acc > 16'd30) tick();
    for (int j = 0; j < 12; j++) begin
      wr_en = 1'b1;
      wr_addr = 4'(j);
      wr_data = 14'(700 + 1300 * j);
      tick();
    end
    wr_addr = 4'd13;
    wr_data = 14'd5;
    tick();
    wr_en = 1'b0;
    for (int c = 0; c < 45000; c++) tick();

    // R8: late write into staging just before a wrap stays pending
    tune = 16'd11;
    while (m_acc < 16'd65500) tick();
    wr_en = 1'b1;
    wr_addr = 4'd0;
    wr_data = 14'd100;
    tick();
    wr_en = 1'b0;
    for (int c = 0; c < 12000; c++) tick();

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule